// File: doc/BRIEF.md
# Next-PC Unit with Jump Delay Slot

This block owns the program counter of a core that fetches a stream of 16-bit compressed instructions, with one 32-bit long-jump form. Each time the core retires an instruction it raises `step` together with the decoded control-flow class, the immediate fields, the value of the register operand, the value of the T8 condition register and the value of the return-address register. The block then moves `pc_o` to the next fetch address.

Jumps are delayed. After a jump retires, `pc_o` points at the instruction that follows it and `slot_o` is high. When that slot instruction retires, the jump target takes effect. While the slot instruction runs, `base_pc_o` gives the jump's own address, so PC-relative arithmetic in the slot uses the jump as its base. Conditional and unconditional branches have no delay slot and redirect at once. The long jump-and-exchange form pulses `mode_flip_o` and flips bit 0 of its target, which switches the core's instruction mode. The register-jump-and-link form drives a write to the return-address register.

A control-flow instruction that retires inside a delay slot is illegal. The block raises `illegal_o`, suppresses every effect of that instruction, and still delivers the pending jump.

Top module: `np_unit`

## Requirements
- R1: While reset is held (rst_n low), and after its release, `pc_o` equals RESET_VEC (default 32'h0000_1000), `slot_o` is 0 and `base_pc_o` equals `pc_o`.
- R2: A step of class SEQ (code 0) advances `pc_o` by 2 at the next clock edge. A cycle without `step` leaves `pc_o` unchanged.
- R3: A JAL step (code 1) targets the upper XLEN-26 bits of (pc+4) concatenated with the 26-bit `jidx`. Its slot instruction sits at pc+4.
- R4: A JALX step (code 2) targets the same address as JAL with bit 0 inverted, and raises `mode_flip_o` in the cycle of the step. No other class raises `mode_flip_o`.
- R5: A JR step (code 3) targets `rx_val`. A JRRA step (code 4) targets `ra_val`.
- R6: A JALR step (code 5) targets `rx_val`. In the cycle of the step it raises `ra_we_o`, with `ra_wdata_o` = pc+4. No other class raises `ra_we_o`.
- R7: After any jump step taken outside a slot, `pc_o` is the jump's address plus its length (2, or 4 for JAL and JALX) and `slot_o` is 1. The next step moves `pc_o` to the target and clears `slot_o`.
- R8: While `slot_o` is 1, `base_pc_o` equals the address of the jump that opened the slot. Otherwise it equals `pc_o`.
- R9: A BEQZ step (code 6) or BNEZ step (code 7) tests `rx_val` against zero. If taken, `pc_o` becomes pc+2+sext(boff[7:0])*4. If not taken, it becomes pc+2. Neither opens a slot.
- R10: A BTEQZ step (code 8) or BTNEZ step (code 9) tests `t8_val` against zero, with the same target rule as R9.
- R11: A B step (code 10) always moves `pc_o` to pc+2+sext(boff[10:0])*4 and opens no slot.
- R12: A jump or branch step taken while `slot_o` is 1 raises `illegal_o` in that cycle. It writes no return address and flips no mode. `pc_o` still moves to the pending jump target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | One instruction retires this cycle |
| cls | input | 4 | Control-flow class of the retiring instruction |
| jidx | input | 26 | Long-jump index field |
| boff | input | 11 | Branch offset field (conditional branches use the low 8 bits) |
| rx_val | input | XLEN | Value of the register operand |
| t8_val | input | XLEN | Value of the T8 condition register |
| ra_val | input | XLEN | Value of the return-address register |
| pc_o | output | XLEN | Address of the next instruction to fetch |
| base_pc_o | output | XLEN | Base address for PC-relative operations |
| slot_o | output | 1 | The instruction at `pc_o` is a delay slot |
| ra_we_o | output | 1 | Write the return-address register |
| ra_wdata_o | output | XLEN | Return address to write |
| mode_flip_o | output | 1 | Toggle the instruction mode |
| illegal_o | output | 1 | Control-flow instruction retired in a delay slot |

## Verification
On every cycle, the assertions check the following:
- A jump opens a slot with `pc_o` just past the jump.
- The slot closes on the next step.
- `base_pc_o` holds the jump's address during the slot.
- The write and flip strobes only accompany a step and never accompany an illegal instruction.
- `illegal_o` appears only inside a slot.

Only the bench's scenarios can show the concrete values:
- each jump target, including the concatenation of the long jump and its bit-0 flip;
- the link address;
- the branch arithmetic with negative offsets;
- the sense of each zero test;
- the delivery of the pending target after an illegal slot instruction.

// File: rtl/np_pkg.sv
package np_pkg;
   typedef enum logic [3:0] {
      NP_SEQ   = 4'd0,
      NP_JAL   = 4'd1,
      NP_JALX  = 4'd2,
      NP_JR    = 4'd3,
      NP_JRRA  = 4'd4,
      NP_JALR  = 4'd5,
      NP_BEQZ  = 4'd6,
      NP_BNEZ  = 4'd7,
      NP_BTEQZ = 4'd8,
      NP_BTNEZ = 4'd9,
      NP_B     = 4'd10
   } np_cls_e;

   function automatic logic np_is_jump(input np_cls_e c);
      return (c == NP_JAL) || (c == NP_JALX) || (c == NP_JR) ||
             (c == NP_JRRA) || (c == NP_JALR);
   endfunction

   function automatic logic np_is_branch(input np_cls_e c);
      return (c == NP_BEQZ) || (c == NP_BNEZ) || (c == NP_BTEQZ) ||
             (c == NP_BTNEZ) || (c == NP_B);
   endfunction
endpackage

// File: rtl/np_cond.sv
module np_cond
   import np_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  np_cls_e           cls,
   input  logic [XLEN-1:0]   rx_val,
   input  logic [XLEN-1:0]   t8_val,
   output logic              taken
);
   logic rx_zero;
   logic t8_zero;

   assign rx_zero = (rx_val == '0);
   assign t8_zero = (t8_val == '0);

   always_comb begin
      unique case (cls)
         NP_BEQZ:  taken = rx_zero;
         NP_BNEZ:  taken = !rx_zero;
         NP_BTEQZ: taken = t8_zero;
         NP_BTNEZ: taken = !t8_zero;
         NP_B:     taken = 1'b1;
         default:  taken = 1'b0;
      endcase
   end
endmodule

// File: rtl/np_target.sv
module np_target
   import np_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int JIDX_W = 26,
   parameter int BOFF_W = 11,
   parameter int COND_W = 8
) (
   input  np_cls_e           cls,
   input  logic [XLEN-1:0]   pc,
   input  logic [JIDX_W-1:0] jidx,
   input  logic [BOFF_W-1:0] boff,
   input  logic [XLEN-1:0]   rx_val,
   input  logic [XLEN-1:0]   ra_val,
   output logic [XLEN-1:0]   seq_pc,
   output logic [XLEN-1:0]   jump_tgt,
   output logic [XLEN-1:0]   br_tgt
);
   localparam logic [XLEN-1:0] SHORT_LEN = XLEN'(2);
   localparam logic [XLEN-1:0] LONG_LEN  = XLEN'(4);

   logic            is_long;
   logic [XLEN-1:0] long_raw;
   logic [XLEN-1:0] off_near;
   logic [XLEN-1:0] off_far;
   logic [XLEN-1:0] br_off;

   assign is_long = (cls == NP_JAL) || (cls == NP_JALX);
   assign seq_pc  = pc + (is_long ? LONG_LEN : SHORT_LEN);

   generate
      if (XLEN > JIDX_W) begin : g_keep_upper
         assign long_raw = {seq_pc[XLEN-1:JIDX_W], jidx};
      end else begin : g_bad_width
         $error("np_target: XLEN must exceed JIDX_W");
         assign long_raw = '0;
      end
   endgenerate

   assign off_near = XLEN'($signed(boff[COND_W-1:0])) << 2;
   assign off_far  = XLEN'($signed(boff)) << 2;
   assign br_off   = (cls == NP_B) ? off_far : off_near;
   assign br_tgt   = pc + SHORT_LEN + br_off;

   always_comb begin
      unique case (cls)
         NP_JAL:  jump_tgt = long_raw;
         NP_JALX: jump_tgt = {long_raw[XLEN-1:1], ~long_raw[0]};
         NP_JRRA: jump_tgt = ra_val;
         default: jump_tgt = rx_val;
      endcase
   end
endmodule

// File: rtl/np_slot.sv
module np_slot #(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            arm,
   input  logic            retire,
   input  logic [XLEN-1:0] jump_pc,
   input  logic [XLEN-1:0] target,
   output logic            slot_q,
   output logic [XLEN-1:0] saved_pc,
   output logic [XLEN-1:0] pend_tgt
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_q   <= 1'b0;
         saved_pc <= '0;
         pend_tgt <= '0;
      end else if (arm) begin
         slot_q   <= 1'b1;
         saved_pc <= jump_pc;
         pend_tgt <= target;
      end else if (retire) begin
         slot_q   <= 1'b0;
      end
   end

   // R7
   slot_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_q && retire |=> !slot_q);

   // R8
   slot_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arm |=> saved_pc == $past(jump_pc));
endmodule

// File: rtl/np_unit.sv
module np_unit
   import np_pkg::*;
#(
   parameter int              XLEN      = 32,
   parameter int              JIDX_W    = 26,
   parameter int              BOFF_W    = 11,
   parameter int              COND_W    = 8,
   parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic [3:0]        cls,
   input  logic [JIDX_W-1:0] jidx,
   input  logic [BOFF_W-1:0] boff,
   input  logic [XLEN-1:0]   rx_val,
   input  logic [XLEN-1:0]   t8_val,
   input  logic [XLEN-1:0]   ra_val,
   output logic [XLEN-1:0]   pc_o,
   output logic [XLEN-1:0]   base_pc_o,
   output logic              slot_o,
   output logic              ra_we_o,
   output logic [XLEN-1:0]   ra_wdata_o,
   output logic              mode_flip_o,
   output logic              illegal_o
);
   localparam logic [XLEN-1:0] SLOT_SKIP = XLEN'(2);

   generate
      if (COND_W > BOFF_W || COND_W < 2) begin : g_cond_chk
         $error("np_unit: COND_W must lie in 2..BOFF_W");
      end
      if (XLEN < 16) begin : g_xlen_chk
         $error("np_unit: XLEN too small");
      end
   endgenerate

   np_cls_e         cls_e;
   logic            is_jump;
   logic            is_branch;
   logic            taken;
   logic            arm;
   logic            fresh;
   logic [XLEN-1:0] pc_q;
   logic [XLEN-1:0] seq_pc;
   logic [XLEN-1:0] jump_tgt;
   logic [XLEN-1:0] br_tgt;
   logic [XLEN-1:0] saved_pc;
   logic [XLEN-1:0] pend_tgt;
   logic            slot_q;

   assign cls_e     = np_cls_e'(cls);
   assign is_jump   = np_is_jump(cls_e);
   assign is_branch = np_is_branch(cls_e);
   assign fresh     = step && !slot_q;
   assign arm       = fresh && is_jump;

   np_cond #(.XLEN(XLEN)) u_cond (
      .cls    (cls_e),
      .rx_val (rx_val),
      .t8_val (t8_val),
      .taken  (taken)
   );

   np_target #(
      .XLEN   (XLEN),
      .JIDX_W (JIDX_W),
      .BOFF_W (BOFF_W),
      .COND_W (COND_W)
   ) u_target (
      .cls      (cls_e),
      .pc       (pc_q),
      .jidx     (jidx),
      .boff     (boff),
      .rx_val   (rx_val),
      .ra_val   (ra_val),
      .seq_pc   (seq_pc),
      .jump_tgt (jump_tgt),
      .br_tgt   (br_tgt)
   );

   np_slot #(.XLEN(XLEN)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (arm),
      .retire   (step && slot_q),
      .jump_pc  (pc_q),
      .target   (jump_tgt),
      .slot_q   (slot_q),
      .saved_pc (saved_pc),
      .pend_tgt (pend_tgt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q <= RESET_VEC;
      end else if (step) begin
         if (slot_q)
            pc_q <= pend_tgt;
         else if (is_branch && taken)
            pc_q <= br_tgt;
         else
            pc_q <= seq_pc;
      end
   end

   assign pc_o        = pc_q;
   assign slot_o      = slot_q;
   assign base_pc_o   = slot_q ? saved_pc : pc_q;
   assign ra_we_o     = fresh && (cls_e == NP_JALR);
   assign ra_wdata_o  = seq_pc + SLOT_SKIP;
   assign mode_flip_o = fresh && (cls_e == NP_JALX);
   assign illegal_o   = step && slot_q && (is_jump || is_branch);

   // R7
   jump_opens_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arm |=> slot_o && (pc_o == $past(seq_pc)));

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(pc_o));

   // R6
   link_needs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ra_we_o |-> step && !illegal_o);

   // R4
   flip_needs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_flip_o |-> step && !slot_o);

   // R12
   illegal_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> slot_o);

   // R9
   branch_no_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fresh && is_branch |=> !slot_o);
endmodule

// File: tb/np_unit_test.sv
module np_unit_test;
   localparam int          XLEN = 32;
   localparam logic [31:0] RV   = 32'h0000_1000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        step = 1'b0;
   logic [3:0]  cls = 4'd0;
   logic [25:0] jidx = '0;
   logic [10:0] boff = '0;
   logic [31:0] rx_val = '0, t8_val = '0, ra_val = '0;
   logic [31:0] pc_o, base_pc_o, ra_wdata_o;
   logic        slot_o, ra_we_o, mode_flip_o, illegal_o;

   int total = 0;
   int bad = 0;

   logic        c_we, c_flip, c_ill;
   logic [31:0] c_wdata;

   always #2 clk = ~clk;

   np_unit #(.XLEN(XLEN), .RESET_VEC(RV)) uut (
      .clk(clk), .rst_n(rst_n), .step(step), .cls(cls), .jidx(jidx),
      .boff(boff), .rx_val(rx_val), .t8_val(t8_val), .ra_val(ra_val),
      .pc_o(pc_o), .base_pc_o(base_pc_o), .slot_o(slot_o),
      .ra_we_o(ra_we_o), .ra_wdata_o(ra_wdata_o),
      .mode_flip_o(mode_flip_o), .illegal_o(illegal_o)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
      check(act === exp, req, act, exp);
   endtask

   // Retire one instruction; comb outputs captured during the step cycle,
   // registered outputs settle by the following falling edge.
   task automatic issue(input logic [3:0] c, input logic [25:0] j, input logic [10:0] b,
                        input logic [31:0] rx, input logic [31:0] t8, input logic [31:0] ra);
      @(negedge clk);
      cls = c; jidx = j; boff = b; rx_val = rx; t8_val = t8; ra_val = ra;
      step = 1'b1;
      #1;
      c_we = ra_we_o; c_flip = mode_flip_o; c_ill = illegal_o; c_wdata = ra_wdata_o;
      @(negedge clk);
      step = 1'b0;
   endtask

   task automatic t_reset();
      chk_eq("R1 pc", pc_o, RV);
      chk_eq("R1 slot", {31'd0, slot_o}, 32'd0);
      chk_eq("R1 base", base_pc_o, RV);
   endtask

   task automatic t_seq();
      logic [31:0] p = pc_o;
      issue(4'd0, '0, '0, 32'd0, 32'd0, 32'd0);
      chk_eq("R2 seq", pc_o, p + 2);
      @(negedge clk);
      chk_eq("R2 hold", pc_o, p + 2);
   endtask

   task automatic t_long(input bit exch);
      logic [31:0] p = pc_o;
      logic [31:0] tgt;
      tgt = {p[31:26] + 6'd0, 26'h2AB_CDE0};
      tgt = {(p + 32'd4) >> 26, 26'h0} | 32'h2AB_CDE0;
      if (exch) tgt[0] = ~tgt[0];
      issue(exch ? 4'd2 : 4'd1, 26'h2AB_CDE0, '0, 32'h55, 32'd0, 32'd0);
      chk_eq(exch ? "R4 flip strobe" : "R4 no flip", {31'd0, c_flip}, {31'd0, exch});
      chk_eq("R6 no link", {31'd0, c_we}, 32'd0);
      chk_eq("R7 slot pc", pc_o, p + 4);
      chk_eq("R7 slot flag", {31'd0, slot_o}, 32'd1);
      chk_eq("R8 base", base_pc_o, p);
      issue(4'd0, '0, '0, 32'd0, 32'd0, 32'd0);
      chk_eq(exch ? "R4 target" : "R3 target", pc_o, tgt);
      chk_eq("R7 closed", {31'd0, slot_o}, 32'd0);
      chk_eq("R8 base after", base_pc_o, tgt);
   endtask

   task automatic t_reg_jumps();
      logic [31:0] p = pc_o;
      issue(4'd3, '0, '0, 32'h0000_4000, 32'd0, 32'h0000_9000);
      chk_eq("R7 jr slot", pc_o, p + 2);
      issue(4'd0, '0, '0, 32'd0, 32'd0, 32'd0);
      chk_eq("R5 jr", pc_o, 32'h0000_4000);
      issue(4'd4, '0, '0, 32'h0000_7000, 32'd0, 32'h0000_5000);
      issue(4'd0, '0, '0, 32'd0, 32'd0, 32'd0);
      chk_eq("R5 jrra", pc_o, 32'h0000_5000);
      p = pc_o;
      issue(4'd5, '0, '0, 32'h0000_6000, 32'd0, 32'd0);
      chk_eq("R6 link we", {31'd0, c_we}, 32'd1);
      chk_eq("R6 link data", c_wdata, p + 4);
      chk_eq("R8 jalr base", base_pc_o, p);
      issue(4'd0, '0, '0, 32'd0, 32'd0, 32'd0);
      chk_eq("R6 jalr target", pc_o, 32'h0000_6000);
   endtask

   task automatic t_branches();
      logic [31:0] p = pc_o;
      issue(4'd6, '0, 11'h0FC, 32'd0, 32'd0, 32'd0);
      chk_eq("R9 beqz taken neg", pc_o, p + 2 - 16);
      chk_eq("R9 no slot", {31'd0, slot_o}, 32'd0);
      p = pc_o;
      issue(4'd6, '0, 11'h003, 32'd5, 32'd0, 32'd0);
      chk_eq("R9 beqz not taken", pc_o, p + 2);
      p = pc_o;
      issue(4'd7, '0, 11'h703, 32'd5, 32'd0, 32'd0);
      chk_eq("R9 bnez taken, upper bits ignored", pc_o, p + 2 + 12);
      p = pc_o;
      issue(4'd8, '0, 11'h010, 32'd5, 32'd0, 32'd0);
      chk_eq("R10 bteqz taken", pc_o, p + 2 + 64);
      p = pc_o;
      issue(4'd9, '0, 11'h010, 32'd0, 32'd0, 32'd0);
      chk_eq("R10 btnez not taken", pc_o, p + 2);
      p = pc_o;
      issue(4'd9, '0, 11'h080, 32'd0, 32'd1, 32'd0);
      chk_eq("R10 btnez taken -128", pc_o, p + 2 - 512);
      p = pc_o;
      issue(4'd10, '0, 11'h400, 32'd0, 32'd0, 32'd0);
      chk_eq("R11 b far neg", pc_o, p + 2 - 4096);
      chk_eq("R11 no slot", {31'd0, slot_o}, 32'd0);
   endtask

   task automatic t_illegal();
      issue(4'd3, '0, '0, 32'h0000_8000, 32'd0, 32'd0);
      issue(4'd5, '0, '0, 32'h0000_A000, 32'd0, 32'd0);
      chk_eq("R12 illegal", {31'd0, c_ill}, 32'd1);
      chk_eq("R12 no link", {31'd0, c_we}, 32'd0);
      chk_eq("R12 pending target", pc_o, 32'h0000_8000);
      chk_eq("R12 slot closed", {31'd0, slot_o}, 32'd0);
      issue(4'd3, '0, '0, 32'h0000_8800, 32'd0, 32'd0);
      issue(4'd2, 26'h1, '0, 32'd0, 32'd0, 32'd0);
      chk_eq("R12 no flip", {31'd0, c_flip}, 32'd0);
      chk_eq("R12 jalx suppressed", pc_o, 32'h0000_8800);
      issue(4'd0, '0, '0, 32'd0, 32'd0, 32'd0);
      chk_eq("R12 normal legal", {31'd0, c_ill}, 32'd0);
   endtask

   initial begin : watchdog
      #400000;
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_seq();
      t_long(1'b0);
      t_long(1'b1);
      t_reg_jumps();
      t_branches();
      t_illegal();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule